// File: doc/BRIEF.md
# Flash Request Screening and Status Flags

This block sits in front of a flash programming engine. Program and erase requests arrive on a valid/ready stream. Each accepted request is screened against four rules: operations enabled, access size matching the configured parallelism, data fitting in one row, and target sector not protected. If any rule is broken, the block raises the matching sticky flag and drops the request. If none is broken, it starts the engine with a one-cycle pulse and holds a busy flag until the engine reports completion or failure.

The flags, the busy bit and two completion flags sit in one 32-bit status word that software reads with no wait state. Software clears any flag by writing 1 to its position. Back-pressure is simple. `req_ready` is high exactly when no operation is in flight. A request transfers on a cycle where `req_valid` and `req_ready` are both high. A requester that sees `req_valid` high and `req_ready` low must hold its address, size and kind unchanged.

Top module: `flash_req_checker`

## Requirements
- R1: After reset the status word reads 0, `req_ready` is 1 and `eng_start` is 0.
- R2: Reading byte offset 0xC returns the status word combinationally. Its layout is: bit 16 busy, bit 7 sequence error, bit 6 size error, bit 5 row error, bit 4 protect error, bit 1 engine-failure flag, bit 0 done flag. All other bits read 0, and every other offset reads 0.
- R3: An accepted request while `cfg_op_en` is 0 sets bit 7.
- R4: An accepted program request (`req_erase`=0) whose `req_size` differs from `cfg_psize` sets bit 6. The size code is 0 byte, 1 half-word, 2 word, 3 double-word. Erase requests never set bit 6.
- R5: An accepted program request whose byte offset within its 16-byte row (`req_addr[3:0]`), plus 2^`req_size`, exceeds 16 sets bit 5. Erase requests never set bit 5.
- R6: An accepted program or erase request sets bit 4 when its sector index `req_addr[19:16]` is below 12 and `cfg_wp_mask` has that index's bit set. Sector indices 12 to 15 are never protected.
- R7: A request that sets any error flag produces no `eng_start` and leaves busy at 0. A clean request gives `eng_start` high for exactly the cycle after acceptance, with busy set at the same edge and `eng_addr`/`eng_erase` holding the request.
- R8: While busy is 1, `req_ready` is 0. Busy returns to 0 on the edge that samples `eng_done` or `eng_err`.
- R9: `eng_done` sets bit 0 and `eng_err` sets bit 1.
- R10: A register write to offset 0xC with `reg_be[0]` high clears each of bits 7,6,5,4,1,0 where `reg_wdata` has a 1. Zeros, writes with `reg_be[0]` low, and writes to bit 16 change nothing.
- R11: When a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (no operation in flight) |
| req_addr | input | 20 | Target byte address |
| req_size | input | 2 | Access size code |
| req_erase | input | 1 | 1 = erase, 0 = program |
| cfg_op_en | input | 1 | Control setting that permits operations |
| cfg_psize | input | 2 | Configured parallelism code |
| cfg_wp_mask | input | 12 | Per-sector write-protect mask |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_addr | output | 20 | Address of the started operation |
| eng_erase | output | 1 | Kind of the started operation |
| eng_done | input | 1 | Engine finished pulse |
| eng_err | input | 1 | Engine failure pulse |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |

## Verification
The bench probes both edges of the row rule. A double-word at offset 8 fills its row exactly and must pass, while a half-word at offset 15 must fail. An off-by-one comparison would flag the first or miss the second. Erase requests carry a mismatched size code to show that the size and row rules look only at programs. Sector index 12 is tried with a fully set mask, which catches a decoder that wraps or indexes past the mask.

The bench also fires a sequence violation and a write-1 clear of the same bit in one cycle to confirm that the set wins; a design that let the clear win would read the flag back as 0. Writes of zeros, writes with byte lane 0 disabled, and writes during an operation show that nothing clears by accident and that busy cannot be cleared by software.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  // access size codes shared by request and configuration
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DWORD = 2'd3
  } size_e;

  // one bit per screening rule
  typedef struct packed {
    logic seq;
    logic par;
    logic row;
    logic wp;
  } req_err_t;

  // status bit positions
  localparam int B_DONE  = 0;
  localparam int B_FAIL  = 1;
  localparam int B_WP    = 4;
  localparam int B_ROW   = 5;
  localparam int B_PAR   = 6;
  localparam int B_SEQ   = 7;
  localparam int B_BUSY  = 16;
  localparam logic [7:0] FLAG_MASK = 8'hF3;
endpackage

// File: rtl/fpc_req_check.sv
module fpc_req_check #(
  parameter int ADDR_W    = 20,
  parameter int SECT_LOG2 = 16,
  parameter int NUM_SECT  = 12,
  parameter int ROW_BYTES = 16
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          size,
  input  logic                erase,
  input  logic                op_en,
  input  logic [1:0]          psize,
  input  logic [NUM_SECT-1:0] wp_mask,
  output fpc_pkg::req_err_t   err
);
  localparam int ROW_LOG2 = $clog2(ROW_BYTES);
  localparam int SPAN_W   = ROW_LOG2 + 2;
  localparam int SIDX_W   = ADDR_W - SECT_LOG2;

  logic [SPAN_W-1:0]   span;
  logic [SIDX_W-1:0]   sidx;
  logic [NUM_SECT-1:0] wp_hit;

  // bytes from row start to end of access
  assign span = SPAN_W'(addr[ROW_LOG2-1:0]) + (SPAN_W'(1) << size);
  assign sidx = addr[ADDR_W-1:SECT_LOG2];

  generate
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
      assign wp_hit[g] = wp_mask[g] && (sidx == SIDX_W'(g));
    end
  endgenerate

  always_comb begin
    err.seq = !op_en;
    err.par = !erase && (size != psize);
    err.row = !erase && (span > SPAN_W'(ROW_BYTES));
    err.wp  = |wp_hit;
  end

  // R4 R5: erase is screened only for enable and protection
  always_comb begin
    if (erase) begin
      a_erase_no_size_r4 : assert (!err.par && !err.row);
    end
  end
endmodule

// File: rtl/fpc_status.sv
module fpc_status (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  fpc_pkg::req_err_t err,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic [7:0]        clr,
  output logic [7:0]        flags,
  output logic              busy,
  output logic              start
);
  import fpc_pkg::*;

  logic       any_err;
  logic [7:0] set_v;

  assign any_err = err.seq | err.par | err.row | err.wp;

  always_comb begin
    set_v         = '0;
    set_v[B_DONE] = eng_done;
    set_v[B_FAIL] = eng_err;
    set_v[B_WP]   = acc & err.wp;
    set_v[B_ROW]  = acc & err.row;
    set_v[B_PAR]  = acc & err.par;
    set_v[B_SEQ]  = acc & err.seq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      busy  <= 1'b0;
      start <= 1'b0;
    end else begin
      // set has priority over clear
      flags <= ((flags & ~clr) | set_v) & FLAG_MASK;
      start <= acc & ~any_err;
      if (eng_done | eng_err) busy <= 1'b0;
      else if (acc & ~any_err) busy <= 1'b1;
    end
  end

  p_err_blocks_start_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (acc && any_err) |=> (!start && !busy));
  p_ok_starts_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !any_err) |=> (start && busy));
  p_start_pulse_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  p_end_clears_busy_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done || eng_err) |=> !busy);
  p_set_wins_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    (acc && err.seq && clr[B_SEQ]) |=> flags[B_SEQ]);
  p_clear_works_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (clr[B_DONE] && !eng_done) |=> !flags[B_DONE]);
  p_done_sets_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> flags[B_DONE]);
endmodule

// File: rtl/flash_req_checker.sv
module flash_req_checker #(
  parameter int ADDR_W    = 20,
  parameter int SECT_LOG2 = 16,
  parameter int NUM_SECT  = 12,
  parameter int ROW_BYTES = 16,
  parameter int REG_AW    = 4,
  parameter logic [3:0] STAT_OFS = 4'hC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic                req_erase,
  input  logic                cfg_op_en,
  input  logic [1:0]          cfg_psize,
  input  logic [NUM_SECT-1:0] cfg_wp_mask,
  output logic                eng_start,
  output logic [ADDR_W-1:0]   eng_addr,
  output logic                eng_erase,
  input  logic                eng_done,
  input  logic                eng_err,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [3:0]          reg_be,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata
);
  import fpc_pkg::*;

  req_err_t   err;
  logic       acc;
  logic       busy;
  logic       hit_stat;
  logic [7:0] clr;
  logic [7:0] flags;

  assign req_ready = !busy;
  assign acc       = req_valid && req_ready;
  assign hit_stat  = (reg_addr == REG_AW'(STAT_OFS));
  assign clr       = (reg_wr && hit_stat && reg_be[0]) ? reg_wdata[7:0] : 8'h00;

  fpc_req_check #(
    .ADDR_W(ADDR_W), .SECT_LOG2(SECT_LOG2),
    .NUM_SECT(NUM_SECT), .ROW_BYTES(ROW_BYTES)
  ) u_check (
    .addr(req_addr), .size(req_size), .erase(req_erase),
    .op_en(cfg_op_en), .psize(cfg_psize), .wp_mask(cfg_wp_mask),
    .err(err)
  );

  fpc_status u_status (
    .clk(clk), .rst_n(rst_n), .acc(acc), .err(err),
    .eng_done(eng_done), .eng_err(eng_err), .clr(clr),
    .flags(flags), .busy(busy), .start(eng_start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_addr  <= '0;
      eng_erase <= 1'b0;
    end else if (acc) begin
      eng_addr  <= req_addr;
      eng_erase <= req_erase;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_stat) begin
      reg_rdata[7:0]    = flags;
      reg_rdata[B_BUSY] = busy;
    end
  end

  p_busy_blocks_ready_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !req_ready);
  p_fwd_stable_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(eng_addr));
endmodule

// File: tb/flash_req_checker_bench.sv
module flash_req_checker_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_erase = 0, cfg_op_en = 1;
  logic [19:0] req_addr = '0;
  logic [1:0] req_size = 2, cfg_psize = 2;
  logic [11:0] cfg_wp_mask = '0;
  logic eng_done = 0, eng_err = 0;
  logic [3:0] reg_addr = 4'hC;
  logic reg_wr = 0;
  logic [3:0] reg_be = 4'hF;
  logic [31:0] reg_wdata = '0;
  wire req_ready, eng_start, eng_erase;
  wire [19:0] eng_addr;
  wire [31:0] reg_rdata;

  int n_chk = 0, n_fail = 0;
  int stub_cnt = 0;
  logic stub_fail = 0;
  logic got_start;

  always #2 clk = ~clk;

  flash_req_checker u_flash_req_checker (.*);

  // engine stub: answers three cycles after a start
  always @(negedge clk) begin
    eng_done <= 1'b0;
    eng_err  <= 1'b0;
    if (stub_cnt == 1) begin
      if (stub_fail) eng_err <= 1'b1;
      else eng_done <= 1'b1;
    end
    if (stub_cnt > 0) stub_cnt <= stub_cnt - 1;
    if (eng_start) stub_cnt <= 3;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 4'hC;
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_be = 4'hF;
  endtask

  task automatic req(input logic [19:0] a, input logic [1:0] s, input logic er);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = s; req_erase = er;
    @(negedge clk);
    req_valid = 0;
    got_start = eng_start;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && !req_ready; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'hC, d);
    chk("R1 status", d, 0);
    chk("R1 ready", {31'b0, req_ready}, 1);
    chk("R1 start", {31'b0, eng_start}, 0);
  endtask

  task automatic t_good();
    logic [31:0] d;
    req(20'h00100, 2, 0);
    chk("R7 start", {31'b0, got_start}, 1);
    chk("R7 addr", {12'b0, eng_addr}, 32'h00100);
    chk("R8 ready low", {31'b0, req_ready}, 0);
    rd(4'hC, d);
    chk("R2 busy bit", d, 32'h0001_0000);
    rd(4'h8, d);
    chk("R2 other offset", d, 0);
    wait_idle();
    rd(4'hC, d);
    chk("R9 done flag", d, 32'h1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(4'hF, 32'h0);
    rd(4'hC, d);
    chk("R10 zero write", d, 32'h1);
    wr(4'hE, 32'hFFFF_FFFF);
    rd(4'hC, d);
    chk("R10 lane0 off", d, 32'h1);
    wr(4'h1, 32'h1);
    rd(4'hC, d);
    chk("R10 clear", d, 0);
  endtask

  task automatic t_seq();
    logic [31:0] d;
    cfg_op_en = 0;
    req(20'h00200, 2, 0);
    cfg_op_en = 1;
    chk("R7 no start seq", {31'b0, got_start}, 0);
    rd(4'hC, d);
    chk("R3 seq flag", d, 32'h80);
    wr(4'h1, 32'h80);
  endtask

  task automatic t_par();
    logic [31:0] d;
    req(20'h00200, 1, 0);
    rd(4'hC, d);
    chk("R4 size flag", d, 32'h40);
    wr(4'h1, 32'hFF);
    req(20'h00203, 0, 1);
    chk("R4 erase ignores size", {31'b0, got_start}, 1);
    wait_idle();
    rd(4'hC, d);
    chk("R4 erase clean", d, 32'h1);
    wr(4'h1, 32'hFF);
  endtask

  task automatic t_row();
    logic [31:0] d;
    req(20'h0000E, 2, 0);
    rd(4'hC, d);
    chk("R5 word across row", d, 32'h20);
    wr(4'h1, 32'hFF);
    cfg_psize = 3;
    req(20'h00008, 3, 0);
    chk("R5 dword fits row", {31'b0, got_start}, 1);
    wait_idle();
    wr(4'h1, 32'hFF);
    cfg_psize = 1;
    req(20'h0000F, 1, 0);
    rd(4'hC, d);
    chk("R5 half at 15", d, 32'h20);
    wr(4'h1, 32'hFF);
    cfg_psize = 2;
  endtask

  task automatic t_wp();
    logic [31:0] d;
    cfg_wp_mask = 12'h008;
    req(20'h30010, 2, 0);
    rd(4'hC, d);
    chk("R6 program protected", d, 32'h10);
    wr(4'h1, 32'hFF);
    req(20'h30000, 2, 1);
    rd(4'hC, d);
    chk("R6 erase protected", d, 32'h10);
    wr(4'h1, 32'hFF);
    cfg_wp_mask = 12'hFFF;
    req(20'hC0000, 2, 0);
    chk("R6 sector 12 free", {31'b0, got_start}, 1);
    cfg_wp_mask = '0;
    wait_idle();
    wr(4'h1, 32'hFF);
  endtask

  task automatic t_fail();
    logic [31:0] d;
    stub_fail = 1;
    req(20'h00400, 2, 0);
    // busy is read-only
    wr(4'hF, 32'hFFFF_FFFF);
    rd(4'hC, d);
    chk("R10 busy kept", d, 32'h0001_0000);
    wait_idle();
    stub_fail = 0;
    rd(4'hC, d);
    chk("R9 fail flag", d, 32'h2);
    chk("R8 ready back", {31'b0, req_ready}, 1);
    wr(4'h1, 32'hFF);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    cfg_op_en = 0;
    @(negedge clk);
    req_valid = 1; req_addr = 20'h00500; req_size = 2; req_erase = 0;
    reg_wr = 1; reg_be = 4'h1; reg_wdata = 32'h80;
    @(negedge clk);
    req_valid = 0; reg_wr = 0; reg_be = 4'hF;
    cfg_op_en = 1;
    rd(4'hC, d);
    chk("R11 set wins", d, 32'h80);
    wr(4'h1, 32'hFF);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_good();
    t_w1c();
    t_seq();
    t_par();
    t_row();
    t_wp();
    t_fail();
    t_setwins();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule